// File: doc/BRIEF.md
# Lockable Watchdog Timer with NMI

A supervision counter for a processor subsystem. Software arms the timer by writing a mode byte over a dedicated privileged write path. The byte carries a run flag and a two-bit period code. Arming clears the count and starts it. From then on the count advances on each prescaled tick. Software must rewrite the run flag before the selected period runs out. If it does not, the block raises a one-cycle non-maskable interrupt pulse and keeps counting for the next period.

The first write that sets the run flag freezes the configuration. After that, writes can no longer change the period code, and the run flag can only be cleared by reset. Writes arriving over the ordinary bus port never reach the mode register. A readback byte shows the run flag, the period code and a lock flag.

Top module: `wdt_nmi_top`

## Requirements
- R1: After synchronous reset, the readback byte is 0x00 and `nmi_o` is low.
- R2: A privileged write whose bit 0 (run) is 1 clears the count and starts it. With the tick high every cycle, `nmi_o` first rises exactly one period after the write edge.
- R3: The period code in bits 2:1 of the written byte selects 2^P0, 2^P1, 2^P2 or 2^P3 ticks, for codes 00, 01, 10 and 11. P0 to P3 are parameters.
- R4: `nmi_o` is a one-cycle pulse. The count then wraps to zero and keeps running, so another pulse follows every full period that passes without a restart.
- R5: A privileged write with run = 1 before overflow restarts the full period. If the restart lands in the same cycle as the terminal tick, the restart wins and no pulse is produced.
- R6: Writes on the ordinary bus port change neither the readback byte nor `nmi_o`, and they do not start the timer.
- R7: Once the lock is set, the period code cannot change. A privileged write with run = 1 and a different code still acts as a restart.
- R8: Once run is 1, a privileged write with run = 0 leaves run at 1 and does not restart the count.
- R9: The count advances only in cycles where `cnt_tick_i` is high.
- R10: The readback byte holds run in bit 0, the period code in bits 2:1 and the lock flag in bit 3; bits 7:4 read 0. Before the lock is set, a privileged write with run = 0 updates the period code without starting the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_tick_i | input | 1 | Prescaled count enable |
| prv_wr_i | input | 1 | Privileged mode-register write strobe |
| prv_wdata_i | input | 8 | Privileged write data |
| bus_wr_i | input | 1 | Ordinary bus write strobe (ignored) |
| bus_wdata_i | input | 8 | Ordinary bus write data (ignored) |
| rd_data_o | output | 8 | Mode-register readback |
| nmi_o | output | 1 | Non-maskable interrupt pulse |

## Verification
A restart write and the terminal tick of a period can fall in the same clock cycle. The bench provokes this by letting a period run to one tick short of overflow. It then issues the privileged restart so that its write edge is the edge that would raise the pulse. It judges the result by requiring `nmi_o` to stay low at that edge and the next pulse to arrive one full period later.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    localparam int RUN_BIT  = 0;
    localparam int SEL_LSB  = 1;
    localparam int LOCK_BIT = 3;

    typedef struct packed {
        logic       lock;
        logic [1:0] sel;
        logic       run;
    } wdt_cfg_t;
endpackage

// File: rtl/wdt_mode_reg.sv
`timescale 1ns/1ps
module wdt_mode_reg
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output wdt_cfg_t   cfg_o,
    output logic       restart_o
);
    wdt_cfg_t cfg_d, cfg_q;
    logic     restart_d;

    always_comb begin
        cfg_d     = cfg_q;
        restart_d = wr_en && wdata[RUN_BIT];
        if (wr_en) begin
            if (!cfg_q.lock) begin
                cfg_d.sel = wdata[SEL_LSB +: 2];
            end
            if (wdata[RUN_BIT]) begin
                cfg_d.run  = 1'b1;
                cfg_d.lock = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o     = cfg_q;
    assign restart_o = restart_d;

    // R8
    run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_q.run |=> cfg_q.run);

    // R7
    sel_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_q.lock |=> $stable(cfg_q.sel));
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter #(
    parameter int P0 = 12,
    parameter int P1 = 14,
    parameter int P2 = 16,
    parameter int P3 = 18
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       run,
    input  logic [1:0] sel,
    input  logic       restart,
    output logic       nmi_o
);
    localparam int LOG_TAB [4] = '{P0, P1, P2, P3};
    localparam int M01   = (P0 > P1) ? P0 : P1;
    localparam int M23   = (P2 > P3) ? P2 : P3;
    localparam int CNT_W = (M01 > M23) ? M01 : M23;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             nmi;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] term_tab [4];
    logic             at_term;

    for (genvar g = 0; g < 4; g++) begin : g_term
        assign term_tab[g] = CNT_W'((64'd1 << LOG_TAB[g]) - 64'd1);
    end

    assign at_term = (st_q.cnt == term_tab[sel]);

    always_comb begin
        st_d     = st_q;
        st_d.nmi = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (run && tick) begin
            if (at_term) begin
                st_d.cnt = '0;
                st_d.nmi = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nmi_o = st_q.nmi;

    // R4
    nmi_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.nmi |=> !st_q.nmi);

    // R5
    restart_wins_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> !st_q.nmi);

    // R9
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(st_q.cnt) && !st_q.nmi);
endmodule

// File: rtl/wdt_nmi_top.sv
`timescale 1ns/1ps
module wdt_nmi_top
    import wdt_pkg::*;
#(
    parameter int PER_LOG_SEL0 = 12,
    parameter int PER_LOG_SEL1 = 14,
    parameter int PER_LOG_SEL2 = 16,
    parameter int PER_LOG_SEL3 = 18
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_tick_i,
    input  logic       prv_wr_i,
    input  logic [7:0] prv_wdata_i,
    input  logic       bus_wr_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] rd_data_o,
    output logic       nmi_o
);
    wdt_cfg_t cfg;
    logic     restart;

    wdt_mode_reg i_mode (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (prv_wr_i),
        .wdata     (prv_wdata_i),
        .cfg_o     (cfg),
        .restart_o (restart)
    );

    wdt_counter #(
        .P0 (PER_LOG_SEL0),
        .P1 (PER_LOG_SEL1),
        .P2 (PER_LOG_SEL2),
        .P3 (PER_LOG_SEL3)
    ) i_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (cnt_tick_i),
        .run     (cfg.run),
        .sel     (cfg.sel),
        .restart (restart),
        .nmi_o   (nmi_o)
    );

    always_comb begin
        rd_data_o                  = '0;
        rd_data_o[RUN_BIT]         = cfg.run;
        rd_data_o[SEL_LSB +: 2]    = cfg.sel;
        rd_data_o[LOCK_BIT]        = cfg.lock;
    end

    // R2
    nmi_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_o |-> rd_data_o[RUN_BIT]);

    // R6
    bus_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && !prv_wr_i && (bus_wdata_i != 8'hxx || 1'b1)) |=> $stable(rd_data_o));
endmodule

// File: tb/test_wdt_nmi_top.sv
`timescale 1ns/1ps
module test_wdt_nmi_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       prv_wr = 1'b0;
    logic [7:0] prv_wd = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wd = '0;
    logic [7:0] rd;
    logic       nmi;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sb[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    always #2.5 clk = ~clk;

    wdt_nmi_top #(
        .PER_LOG_SEL0 (3),
        .PER_LOG_SEL1 (4),
        .PER_LOG_SEL2 (5),
        .PER_LOG_SEL3 (6)
    ) i_wdt_nmi_top (
        .clk         (clk),
        .rst         (rst),
        .cnt_tick_i  (tick),
        .prv_wr_i    (prv_wr),
        .prv_wdata_i (prv_wd),
        .bus_wr_i    (bus_wr),
        .bus_wdata_i (bus_wd),
        .rd_data_o   (rd),
        .nmi_o       (nmi)
    );

    // monitor: pop expected items and compare mid-cycle
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb.pop_front();
            act = (it.kind == 0) ? rd : {7'd0, nmi};
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s %s actual=%02h expected=%02h",
                         it.req, (it.kind == 0) ? "rd_data" : "nmi", act, it.exp);
            end
        end
    end

    task automatic exp_rd(input logic [7:0] v, input string req);
        sb.push_back('{0, v, req});
    endtask

    task automatic exp_nmi(input logic v, input string req);
        sb.push_back('{1, {7'd0, v}, req});
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // called just after an edge; the following edge is the write edge
    task automatic pwrite(input logic [7:0] d);
        prv_wr = 1'b1;
        prv_wd = d;
        step(1);
        prv_wr = 1'b0;
    endtask

    task automatic bwrite(input logic [7:0] d);
        bus_wr = 1'b1;
        bus_wd = d;
        step(1);
        bus_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(2);
        rst = 1'b0;
    endtask

    task automatic period_check(input int p, input string req);
        step(p - 1);
        exp_nmi(1'b0, req);
        step(1);
        exp_nmi(1'b1, req);
    endtask

    initial begin
        step(3);
        exp_rd(8'h00, "R1");
        exp_nmi(1'b0, "R1");
        rst = 1'b0;
        step(1);

        // R6: bus writes ignored
        bwrite(8'h07);
        exp_rd(8'h00, "R6");
        step(20);
        exp_nmi(1'b0, "R6");

        // R10: pre-lock write without run updates code only
        pwrite(8'h04);
        exp_rd(8'h04, "R10");
        step(40);
        exp_nmi(1'b0, "R10");
        exp_rd(8'h04, "R10");

        // R2 / R4: start with code 01 (16 ticks)
        pwrite(8'h03);
        exp_rd(8'h0B, "R2");
        period_check(16, "R2");
        step(1);
        exp_nmi(1'b0, "R4");
        step(14);
        exp_nmi(1'b0, "R4");
        step(1);
        exp_nmi(1'b1, "R4");

        // R5: restart before overflow
        step(10);
        pwrite(8'h03);
        period_check(16, "R5");

        // R5: restart collides with terminal tick
        step(15);
        pwrite(8'h03);
        exp_nmi(1'b0, "R5");
        period_check(16, "R5");

        // R7: different code after lock is a restart, code unchanged
        step(6);
        pwrite(8'h07);
        exp_rd(8'h0B, "R7");
        period_check(16, "R7");

        // R8: run=0 write after lock neither clears run nor restarts
        step(4);
        pwrite(8'h00);
        exp_rd(8'h0B, "R8");
        step(10);
        exp_nmi(1'b0, "R8");
        step(1);
        exp_nmi(1'b1, "R8");

        // R9: no ticks, no progress
        tick = 1'b0;
        step(40);
        exp_nmi(1'b0, "R9");
        tick = 1'b1;
        period_check(16, "R9");

        // R1: reset while running
        rst = 1'b1;
        step(1);
        exp_rd(8'h00, "R1");
        exp_nmi(1'b0, "R1");
        rst = 1'b0;
        step(1);

        // R3: remaining period codes
        pwrite(8'h01);
        exp_rd(8'h09, "R3");
        period_check(8, "R3");
        do_reset();
        pwrite(8'h05);
        exp_rd(8'h0D, "R3");
        period_check(32, "R3");
        do_reset();
        pwrite(8'h07);
        exp_rd(8'h0F, "R3");
        period_check(64, "R3");

        step(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule